// File: doc/BRIEF.md
# Display Controller Control and Interrupt Unit

This block is the control and status register file of a display controller. A processor reaches it with 32-bit register writes and combinational register reads at word offsets. It holds the run, stop and update-request controls, a bit that picks between continuous video output and one-shot command transfers, a window of layer and timing configuration words, and an interrupt enable, clear and status set. It drives a single level-sensitive interrupt line.

Every configuration word has two copies. Software writes the pending copy. The active copy feeds the pixel pipeline through `activeCfg`. How the pending copy reaches the active one depends on the mode. In video mode, software first starts the controller. It then asks for an update, and the new words are taken at the next frame boundary, which also raises an update-done flag. In command mode there is no shadowing, and the configuration is taken only when the controller goes from idle to running. Frame boundaries, tearing-effect, underflow and vsync reach the block as single-cycle input pulses from the pipeline.

Top module: `dispc_ctrl_unit`

## Requirements
- R1: After reset every readable register reads 0, `irq` is 0, `activeCfg` is all zero and the mode is video.
- R2: At offset 0x04, writing bit 0 = 1 while idle starts the controller. Reads return running in bit 0, stop pending in bit 1 and update pending in bit 2, and 0 in all other bits. Writing bit 0 while already running has no effect.
- R3: At offset 0x08, bit 0 selects command mode when 1 and video mode when 0, and it reads back in bit 0. A write to it while running is ignored.
- R4: The configuration words sit at 0x30 + 4·i for i < CFG_WORDS. Writes go to the pending copy, which reads back, and `activeCfg` does not change. Word-aligned offsets beyond the last word read 0 and store nothing.
- R5: In the cycle the controller goes from idle to running, in either mode, every pending word is copied to `activeCfg` (word i at bits 32·i upward).
- R6: In video mode while running, writing 0x04 bit 2 sets update pending. The next frame-end pulse copies pending to active, clears update pending and sets status bit 4. An update request while idle or in command mode is ignored.
- R7: In video mode while running, writing 0x04 bit 1 sets stop pending. The next frame-end pulse stops the controller and sets status bit 0. A stop request in command mode is ignored.
- R8: In command mode, a frame-end pulse while running ends the transfer: running clears and status bit 0 sets.
- R9: Pulses on `teEvt`, `errEvt` and `vsyncEvt` set status bits 1, 2 and 5 whether enabled or not. A frame-end pulse while idle sets nothing.
- R10: Status reads at 0x1E8, with bit 3 and bits 31:6 always 0. Writing 1s to 0x1E4 clears those status bits, and 0s leave them alone. A bit that is set and cleared in the same cycle ends up set.
- R11: Enable is at 0x1E0 and stores only bits 0, 1, 2, 4 and 5. `irq` is 1 exactly when some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register accessed |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| frameEnd | input | 1 | Frame boundary pulse from the pipeline |
| teEvt | input | 1 | Tearing-effect pulse |
| errEvt | input | 1 | Underflow pulse |
| vsyncEvt | input | 1 | Vsync pulse |
| irq | output | 1 | Level interrupt |
| activeCfg | output | 32·CFG_WORDS | Active configuration words |

## Verification
The bench builds the unit with CFG_WORDS = 3 and ADDR_W = 12. With three words the configuration window has a size that is not a power of two, so the word at 0x3C lies just past the end of the window and has to read as zero while every word inside the window commits. A behavioural model runs next to the design and is compared each cycle. Directed sequences step through video start, update-then-commit, stop at a frame boundary, a command-mode one-shot transfer, and writes that must be ignored.

// File: rtl/dispc_pkg.sv
package dispc_pkg;
  localparam logic [31:0] OFF_CTRL  = 32'h004;
  localparam logic [31:0] OFF_MODE  = 32'h008;
  localparam logic [31:0] CFG_BASE  = 32'h030;
  localparam logic [31:0] OFF_IEN   = 32'h1E0;
  localparam logic [31:0] OFF_ICLR  = 32'h1E4;
  localparam logic [31:0] OFF_ISTS  = 32'h1E8;

  localparam int STS_W     = 6;
  localparam int BIT_DONE  = 0;
  localparam int BIT_TE    = 1;
  localparam int BIT_ERR   = 2;
  localparam int BIT_UPD   = 4;
  localparam int BIT_VSYNC = 5;
  localparam logic [STS_W-1:0] STS_MASK = 6'b110111;

  typedef struct packed {
    logic             cfgHit;
    logic [7:0]       cfgIdx;
    logic             cfgWr;
    logic             commit;
    logic             enWr;
    logic             clrWr;
    logic [STS_W-1:0] evtSet;
    logic [31:0]      data;
  } dpStrobe_t;
endpackage

// File: rtl/dispc_ctrl.sv
module dispc_ctrl
  import dispc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CFG_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic              frameEnd,
  input  logic              teEvt,
  input  logic              errEvt,
  input  logic              vsyncEvt,
  output dpStrobe_t         stb,
  output logic              running,
  output logic              stopPend,
  output logic              updPend,
  output logic              cmdMode,
  output logic [31:0]       ctrlWord
);
  localparam logic [31:0] CFG_END = CFG_BASE + 32'(4 * CFG_WORDS);

  logic [31:0] addrW;
  logic [31:0] cfgOffs;
  logic hitCtrl, hitMode;
  logic runStart, stopReq, updReq;
  logic frameLive, finishCmd, finishVid, updCommit;

  assign addrW   = 32'(addr);
  assign cfgOffs = addrW - CFG_BASE;
  assign hitCtrl = wrEn && (addrW == OFF_CTRL);
  assign hitMode = wrEn && (addrW == OFF_MODE);

  // requests are qualified by the current state; those that do not apply vanish
  assign runStart  = hitCtrl && wrData[0] && !running;
  assign stopReq   = hitCtrl && wrData[1] && running && !cmdMode;
  assign updReq    = hitCtrl && wrData[2] && running && !cmdMode;

  assign frameLive = frameEnd && running;
  assign finishCmd = frameLive && cmdMode;
  assign finishVid = frameLive && !cmdMode && stopPend;
  assign updCommit = frameLive && !cmdMode && updPend;

  always_comb begin
    stb        = '0;
    stb.data   = wrData;
    stb.cfgHit = (addrW >= CFG_BASE) && (addrW < CFG_END) && (addrW[1:0] == 2'b00);
    stb.cfgIdx = cfgOffs[9:2];
    stb.cfgWr  = wrEn && stb.cfgHit;
    stb.enWr   = wrEn && (addrW == OFF_IEN);
    stb.clrWr  = wrEn && (addrW == OFF_ICLR);
    stb.commit = runStart || updCommit;
    stb.evtSet[BIT_DONE]  = finishCmd || finishVid;
    stb.evtSet[BIT_TE]    = teEvt;
    stb.evtSet[BIT_ERR]   = errEvt;
    stb.evtSet[BIT_UPD]   = updCommit;
    stb.evtSet[BIT_VSYNC] = vsyncEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      stopPend <= 1'b0;
      updPend  <= 1'b0;
      cmdMode  <= 1'b0;
    end else begin
      if (runStart) running <= 1'b1;
      else if (finishCmd || finishVid) running <= 1'b0;

      if (finishCmd || finishVid) stopPend <= 1'b0;
      else if (stopReq) stopPend <= 1'b1;

      if (finishCmd || finishVid) updPend <= 1'b0;
      else if (updReq) updPend <= 1'b1;
      else if (updCommit) updPend <= 1'b0;

      if (hitMode && !running) cmdMode <= wrData[0];
    end
  end

  assign ctrlWord = {29'd0, updPend, stopPend, running};
endmodule

// File: rtl/dispc_dp.sv
module dispc_dp
  import dispc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CFG_WORDS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              stb,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [31:0]            ctrlWord,
  input  logic                   cmdMode,
  output logic [31:0]            rdData,
  output logic                   irq,
  output logic [32*CFG_WORDS-1:0] pendCfg,
  output logic [32*CFG_WORDS-1:0] activeCfg,
  output logic [STS_W-1:0]       sts
);
  logic [STS_W-1:0] en;
  logic [STS_W-1:0] clrMask;
  logic [31:0]      cfgRd;
  logic [31:0]      addrW;

  assign addrW = 32'(addr);

  for (genvar i = 0; i < CFG_WORDS; i++) begin : gWord
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendCfg[32*i +: 32]   <= '0;
        activeCfg[32*i +: 32] <= '0;
      end else begin
        if (stb.cfgWr && stb.cfgIdx == 8'(i)) pendCfg[32*i +: 32] <= stb.data;
        if (stb.commit) activeCfg[32*i +: 32] <= pendCfg[32*i +: 32];
      end
    end
  end

  assign clrMask = stb.clrWr ? stb.data[STS_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      en  <= '0;
      sts <= '0;
    end else begin
      if (stb.enWr) en <= stb.data[STS_W-1:0] & STS_MASK;
      sts <= ((sts & ~clrMask) | stb.evtSet) & STS_MASK;
    end
  end

  assign irq = |(sts & en);

  always_comb begin
    cfgRd = '0;
    for (int i = 0; i < CFG_WORDS; i++)
      if (stb.cfgIdx == 8'(i)) cfgRd = pendCfg[32*i +: 32];
  end

  always_comb begin
    rdData = '0;
    if (stb.cfgHit) rdData = cfgRd;
    else if (addrW == OFF_CTRL) rdData = ctrlWord;
    else if (addrW == OFF_MODE) rdData = {31'd0, cmdMode};
    else if (addrW == OFF_IEN) rdData = 32'(en);
    else if (addrW == OFF_ISTS) rdData = 32'(sts);
  end
endmodule

// File: rtl/dispc_ctrl_unit.sv
module dispc_ctrl_unit
  import dispc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CFG_WORDS = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wrData,
  output logic [31:0]             rdData,
  input  logic                    frameEnd,
  input  logic                    teEvt,
  input  logic                    errEvt,
  input  logic                    vsyncEvt,
  output logic                    irq,
  output logic [32*CFG_WORDS-1:0] activeCfg
);
  dpStrobe_t stb;
  logic running, stopPend, updPend, cmdMode;
  logic [31:0] ctrlWord;
  logic [32*CFG_WORDS-1:0] pendCfg;
  logic [STS_W-1:0] sts;

  dispc_ctrl #(.ADDR_W(ADDR_W), .CFG_WORDS(CFG_WORDS)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .frameEnd(frameEnd), .teEvt(teEvt), .errEvt(errEvt), .vsyncEvt(vsyncEvt),
    .stb(stb), .running(running), .stopPend(stopPend), .updPend(updPend),
    .cmdMode(cmdMode), .ctrlWord(ctrlWord)
  );

  dispc_dp #(.ADDR_W(ADDR_W), .CFG_WORDS(CFG_WORDS)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .ctrlWord(ctrlWord),
    .cmdMode(cmdMode), .rdData(rdData), .irq(irq), .pendCfg(pendCfg),
    .activeCfg(activeCfg), .sts(sts)
  );
endmodule

// File: rtl/dispc_ctrl_chk.sv
module dispc_ctrl_chk #(
  parameter int CFG_WORDS = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    running,
  input logic                    stopPend,
  input logic                    updPend,
  input logic                    cmdMode,
  input logic                    irq,
  input logic [5:0]              sts,
  input logic [32*CFG_WORDS-1:0] pendCfg,
  input logic [32*CFG_WORDS-1:0] activeCfg
);
  assert_start_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> activeCfg == $past(pendCfg));

  assert_update_commit_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sts[4]) |-> activeCfg == $past(pendCfg));

  assert_stop_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> sts[0]);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !$past(running)) |-> $stable(activeCfg));

  assert_idle_no_pending_R2: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!updPend && !stopPend));

  assert_cmd_no_pending_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdMode |-> (!updPend && !stopPend));

  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (|sts));
endmodule

bind dispc_ctrl_unit dispc_ctrl_chk #(.CFG_WORDS(CFG_WORDS)) uChk (
  .clk(clk), .rstN(rstN), .running(running), .stopPend(stopPend),
  .updPend(updPend), .cmdMode(cmdMode), .irq(irq), .sts(sts),
  .pendCfg(pendCfg), .activeCfg(activeCfg)
);

// File: tb/tb_dispc_ctrl_unit.sv
module tb_dispc_ctrl_unit;
  localparam int NW = 3;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wrData = '0;
  logic frameEnd = 1'b0, teEvt = 1'b0, errEvt = 1'b0, vsyncEvt = 1'b0;
  logic [31:0] rdData;
  logic irq;
  logic [32*NW-1:0] activeCfg;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dispc_ctrl_unit #(.ADDR_W(AW), .CFG_WORDS(NW)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .frameEnd(frameEnd), .teEvt(teEvt), .errEvt(errEvt),
    .vsyncEvt(vsyncEvt), .irq(irq), .activeCfg(activeCfg)
  );

  // behavioural reference model
  bit mRun, mStop, mUpd, mCmd;
  bit [31:0] mPend [NW];
  bit [31:0] mAct [NW];
  bit [5:0] mEn, mSts;

  function automatic bit [31:0] mRead(input int a);
    if (a >= 'h30 && a < 'h30 + 4*NW && a % 4 == 0) return mPend[(a - 'h30) / 4];
    case (a)
      'h004: return {29'd0, mUpd, mStop, mRun};
      'h008: return {31'd0, mCmd};
      'h1E0: return {26'd0, mEn};
      'h1E8: return {26'd0, mSts};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; mStop = 0; mUpd = 0; mCmd = 0; mEn = 0; mSts = 0;
      for (int i = 0; i < NW; i++) begin mPend[i] = 0; mAct[i] = 0; end
    end else begin
      int a;
      bit start, stopQ, updQ, fin, upc;
      bit [5:0] setM, clrM;
      a = int'(addr);
      start = wrEn && a == 'h004 && wrData[0] && !mRun;
      stopQ = wrEn && a == 'h004 && wrData[1] && mRun && !mCmd;
      updQ  = wrEn && a == 'h004 && wrData[2] && mRun && !mCmd;
      fin   = frameEnd && mRun && (mCmd || mStop);
      upc   = frameEnd && mRun && !mCmd && mUpd;
      setM = 0;
      setM[0] = fin; setM[1] = teEvt; setM[2] = errEvt; setM[4] = upc; setM[5] = vsyncEvt;
      clrM = (wrEn && a == 'h1E4) ? wrData[5:0] : 6'd0;
      if (start || upc) for (int i = 0; i < NW; i++) mAct[i] = mPend[i];
      if (wrEn && a >= 'h30 && a < 'h30 + 4*NW && a % 4 == 0) mPend[(a - 'h30) / 4] = wrData;
      if (wrEn && a == 'h1E0) mEn = wrData[5:0] & 6'b110111;
      mSts = ((mSts & ~clrM) | setM) & 6'b110111;
      if (wrEn && a == 'h008 && !mRun) mCmd = wrData[0];
      if (fin) begin mStop = 0; mUpd = 0; end
      else begin
        if (stopQ) mStop = 1;
        if (updQ) mUpd = 1; else if (upc) mUpd = 0;
      end
      if (start) mRun = 1; else if (fin) mRun = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(posedge clk) begin
    #5;
    if (rstN && !finished) begin
      int a;
      a = int'(addr);
      chk("R11 irq", {31'd0, irq}, {31'd0, |(mSts & mEn)});
      for (int i = 0; i < NW; i++) chk("R5 activeCfg", activeCfg[32*i +: 32], mAct[i]);
      chk(a == 'h004 ? "R2 ctrl read" : a == 'h008 ? "R3 mode read" :
          a == 'h1E8 ? "R10 status read" : a == 'h1E0 ? "R11 enable read" : "R4 read",
          rdData, mRead(a));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = AW'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rdChk(input string tag, input int a, input logic [31:0] exp);
    @(negedge clk); addr = AW'(a); #2;
    chk(tag, rdData, exp);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: frameEnd = 1'b1;
      1: teEvt = 1'b1;
      2: errEvt = 1'b1;
      default: vsyncEvt = 1'b1;
    endcase
    @(negedge clk);
    frameEnd = 1'b0; teEvt = 1'b0; errEvt = 1'b0; vsyncEvt = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdChk("R1 ctrl", 'h004, 32'd0);
    rdChk("R1 mode", 'h008, 32'd0);
    rdChk("R1 status", 'h1E8, 32'd0);
    rdChk("R1 enable", 'h1E0, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 active", 32'(activeCfg[31:0]), 32'd0);

    // R4 pending writes, window bound
    wr('h030, 32'hA0A0_0001); wr('h034, 32'hB0B0_0002); wr('h038, 32'hC0C0_0003);
    wr('h03C, 32'hDEAD_BEEF);
    rdChk("R4 word0", 'h030, 32'hA0A0_0001);
    rdChk("R4 word2", 'h038, 32'hC0C0_0003);
    rdChk("R4 past window", 'h03C, 32'd0);
    chk("R4 active held", activeCfg[63:32], 32'd0);

    // R9/R11/R10 interrupt path
    pulse(1);
    rdChk("R9 te latched while disabled", 'h1E8, 32'h2);
    chk("R11 irq masked", {31'd0, irq}, 32'd0);
    wr('h1E0, 32'hFFFF_FFFF);
    rdChk("R11 enable stored bits", 'h1E0, 32'h37);
    chk("R11 irq asserted", {31'd0, irq}, 32'd1);
    wr('h1E4, 32'h0);
    rdChk("R10 zero clear no effect", 'h1E8, 32'h2);
    wr('h1E4, 32'h2);
    rdChk("R10 cleared", 'h1E8, 32'h0);
    chk("R11 irq dropped", {31'd0, irq}, 32'd0);
    fork
      wr('h1E4, 32'h20);
      pulse(3);
    join
    rdChk("R10 set wins over clear", 'h1E8, 32'h20);
    pulse(2);
    rdChk("R9 underflow", 'h1E8, 32'h24);
    wr('h1E4, 32'hFF);

    // R6 update request while idle is ignored
    wr('h004, 32'h4);
    rdChk("R6 idle update ignored", 'h004, 32'd0);
    pulse(0);
    rdChk("R9 idle frame end sets nothing", 'h1E8, 32'd0);

    // R5 start in video mode commits
    wr('h004, 32'h1);
    chk("R5 commit word1", activeCfg[63:32], 32'hB0B0_0002);
    rdChk("R2 running", 'h004, 32'h1);
    wr('h004, 32'h1);
    rdChk("R2 run while running ignored", 'h004, 32'h1);
    wr('h008, 32'h1);
    rdChk("R3 mode write while running ignored", 'h008, 32'd0);

    // R6 update at frame boundary
    wr('h034, 32'h1234_5678);
    wr('h004, 32'h4);
    rdChk("R6 update pending", 'h004, 32'h5);
    chk("R6 active before boundary", activeCfg[63:32], 32'hB0B0_0002);
    pulse(0);
    chk("R6 active after boundary", activeCfg[63:32], 32'h1234_5678);
    rdChk("R6 update done status", 'h1E8, 32'h10);
    rdChk("R6 pending cleared", 'h004, 32'h1);

    // R7 stop at frame boundary
    wr('h004, 32'h2);
    rdChk("R7 stop pending", 'h004, 32'h3);
    pulse(0);
    rdChk("R7 stopped", 'h004, 32'd0);
    rdChk("R7 done status", 'h1E8, 32'h11);
    wr('h1E4, 32'hFF);

    // R3/R8 command mode one-shot
    wr('h008, 32'h1);
    rdChk("R3 command mode", 'h008, 32'h1);
    wr('h004, 32'h4);
    rdChk("R6 command idle update ignored", 'h004, 32'd0);
    wr('h038, 32'h5555_AAAA);
    chk("R4 cmd no early commit", activeCfg[95:64], 32'hC0C0_0003);
    wr('h004, 32'h1);
    chk("R5 cmd commit on run", activeCfg[95:64], 32'h5555_AAAA);
    wr('h004, 32'h6);
    rdChk("R7 cmd stop ignored", 'h004, 32'h1);
    pulse(0);
    rdChk("R8 transfer ended", 'h004, 32'd0);
    rdChk("R8 done status", 'h1E8, 32'h1);
    chk("R11 irq on done", {31'd0, irq}, 32'd1);
    wr('h008, 32'h0);
    rdChk("R3 back to video", 'h008, 32'd0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule